// File: doc/BRIEF.md
# Serial Controller Interrupt Aggregator

This block turns the status lines of a serial controller into sticky second-level interrupt flags and a single interrupt request. It watches three FIFO status lines: transmit idle, transmit space free and receive data valid. It also watches four DMA buffer-active flags (transmit A/B, receive A/B) and two error strobes (receive overrun, transmit underrun). Each line is turned into a one-cycle event and latched into its own flag.

A per-source mode bit sets how each FIFO status line is sensed: on its rising edge, or for as long as it is high. A DMA buffer counts as complete when its active flag falls. Software clears flags by writing ones to a clear port. A mask selects which flags can raise the request. A top-level enable gates the request as a whole.

Top module: `sc_irq_aggregator`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released with all sources low, `flags_o` is all zeros and `irq_o` is 0.
- R2: With a FIFO source's bit in `level_mode` at 0 (edge mode), its flag sets once on each 0-to-1 transition of its status line. FIFO flag bits are 0 (transmit idle), 1 (transmit space free) and 2 (receive valid). A flag cleared while the line stays high stays cleared.
- R3: With the source's `level_mode` bit at 1 (level mode), the flag is set in every cycle the line is high, so a clear written while the line is high leaves it set.
- R4: DMA completion flags set on the 1-to-0 transition of `dma_active`. Bits 0..3 of `dma_active` map to flag bits 3..6 (transmit A, transmit B, receive A, receive B). A 0-to-1 transition has no effect.
- R5: A high cycle on `err_strobe[0]` (receive overrun) sets flag bit 7, and a high cycle on `err_strobe[1]` (transmit underrun) sets flag bit 8.
- R6: Flags stay set after their source goes away. A cycle with `clr_we` high clears exactly the flags whose `clr_mask` bit is 1.
- R7: When an event and a clear for the same flag fall in the same cycle, the flag is set after that cycle.
- R8: `irq_o` is 1 exactly when `top_enable` is 1 and at least one flag is set whose `irq_enable` bit is 1. Masked flags still show in `flags_o`.
- R9: In edge mode, a FIFO status line that is already high when reset is released counts as one rising edge in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_status | input | 3 | Transmit idle, transmit free, receive valid |
| level_mode | input | 3 | Per FIFO source: 1 = level sensing, 0 = rising edge |
| dma_active | input | 4 | Buffer-active flags: tx A, tx B, rx A, rx B |
| err_strobe | input | 2 | Receive overrun, transmit underrun strobes |
| irq_enable | input | 9 | Per-flag interrupt mask, 1 = enabled |
| clr_we | input | 1 | Clear write strobe |
| clr_mask | input | 9 | Write-one-to-clear data |
| top_enable | input | 1 | Top-level enable for the request |
| flags_o | output | 9 | Latched second-level flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default counts: three FIFO sources, four DMA buffers and two error strobes, giving nine flags. At these values every flag position can be reached on its own. Both sensing modes can be compared on neighbouring FIFO bits, and the event-versus-clear race can be driven on any single flag. Masking is checked by placing the set flag both inside and outside the enabled subset.

// File: rtl/sc_irq_pkg.sv
package sc_irq_pkg;

  // Next value of one sticky flag: an event outranks a clear.
  function automatic logic flag_next(logic cur, logic clr, logic evt);
    return evt | (cur & ~clr);
  endfunction

  // Event detector for one status line.
  function automatic logic sense_hit(logic cur, logic prev, logic level, logic falling);
    logic hit;
    if (falling)    hit = prev & ~cur;
    else if (level) hit = cur;
    else            hit = cur & ~prev;
    return hit;
  endfunction

endpackage

// File: rtl/sc_irq_edge_sense.sv
module sc_irq_edge_sense
  import sc_irq_pkg::*;
#(
  parameter int unsigned WIDTH   = 3,
  parameter bit          FALLING = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sig,
  input  logic [WIDTH-1:0] level_mode,
  output logic [WIDTH-1:0] evt
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sig;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign evt[i] = sense_hit(sig[i], prev_q[i], level_mode[i], FALLING);

    if (FALLING) begin : g_fall
      // R4: a completion event can only appear once the active flag is low
      p_fall_low_r4: assert property (@(posedge clk) disable iff (rst)
        evt[i] |-> !sig[i]);
      // R4: a rising active flag never produces an event
      p_rise_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (sig[i] && !$past(sig[i])) |-> !evt[i]);
    end else begin : g_rise
      // R2: events only while the status line is high
      p_hit_high_r2: assert property (@(posedge clk) disable iff (rst)
        evt[i] |-> sig[i]);
      // R3: level mode fires every cycle the line is high
      p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (level_mode[i] && sig[i]) |-> evt[i]);
    end
  end

endmodule

// File: rtl/sc_irq_flag_bank.sv
module sc_irq_flag_bank
  import sc_irq_pkg::*;
#(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags_q
);

  logic [N-1:0] clr_hit;
  logic [N-1:0] flags_d;

  assign clr_hit = clr_we ? clr_mask : '0;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign flags_d[i] = flag_next(flags_q[i], clr_hit[i], evt[i]);

    // R6: a set flag with no clear stays set
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !clr_hit[i]) |=> flags_q[i]);
    // R7: an event always leaves the flag set, clear or not
    p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flags_q[i]);
    // R6: a flag does not set without an event
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
      (!flags_q[i] && !evt[i]) |=> !flags_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

endmodule

// File: rtl/sc_irq_aggregator.sv
module sc_irq_aggregator #(
  parameter int unsigned FIFO_SRC = 3,
  parameter int unsigned DMA_SRC  = 4,
  parameter int unsigned ERR_SRC  = 2,
  localparam int unsigned NFLAG   = FIFO_SRC + DMA_SRC + ERR_SRC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FIFO_SRC-1:0] fifo_status,
  input  logic [FIFO_SRC-1:0] level_mode,
  input  logic [DMA_SRC-1:0]  dma_active,
  input  logic [ERR_SRC-1:0]  err_strobe,
  input  logic [NFLAG-1:0]    irq_enable,
  input  logic                clr_we,
  input  logic [NFLAG-1:0]    clr_mask,
  input  logic                top_enable,
  output logic [NFLAG-1:0]    flags_o,
  output logic                irq_o
);

  logic [FIFO_SRC-1:0] fifo_evt;
  logic [DMA_SRC-1:0]  dma_evt;
  logic [NFLAG-1:0]    all_evt;
  logic [NFLAG-1:0]    live_flags;

  sc_irq_edge_sense #(.WIDTH(FIFO_SRC), .FALLING(1'b0)) u_fifo_sense (
    .clk(clk), .rst(rst), .sig(fifo_status), .level_mode(level_mode), .evt(fifo_evt)
  );

  sc_irq_edge_sense #(.WIDTH(DMA_SRC), .FALLING(1'b1)) u_dma_sense (
    .clk(clk), .rst(rst), .sig(dma_active), .level_mode({DMA_SRC{1'b0}}), .evt(dma_evt)
  );

  assign all_evt = {err_strobe, dma_evt, fifo_evt};

  sc_irq_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .evt(all_evt), .clr_we(clr_we), .clr_mask(clr_mask),
    .flags_q(flags_o)
  );

  assign live_flags = flags_o & irq_enable;
  assign irq_o      = top_enable & (|live_flags);

  // R8: request is gated by the top-level enable
  p_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !top_enable |-> !irq_o);
  // R8: no enabled flag set, no request
  p_mask_r8: assert property (@(posedge clk) disable iff (rst)
    ((flags_o & irq_enable) == '0) |-> !irq_o);
  // R5: an error strobe always leaves its flag set
  p_err_latch_r5: assert property (@(posedge clk) disable iff (rst)
    err_strobe[0] |=> flags_o[FIFO_SRC+DMA_SRC]);

endmodule

// File: tb/sc_irq_aggregator_tb.sv
module sc_irq_aggregator_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] fifo_status = '0;
  logic [2:0] level_mode = '0;
  logic [3:0] dma_active = '0;
  logic [1:0] err_strobe = '0;
  logic [8:0] irq_enable = '0;
  logic       clr_we = 1'b0;
  logic [8:0] clr_mask = '0;
  logic       top_enable = 1'b0;
  logic [8:0] flags_o;
  logic       irq_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sc_irq_aggregator u_dut (
    .clk(clk), .rst(rst), .fifo_status(fifo_status), .level_mode(level_mode),
    .dma_active(dma_active), .err_strobe(err_strobe), .irq_enable(irq_enable),
    .clr_we(clr_we), .clr_mask(clr_mask), .top_enable(top_enable),
    .flags_o(flags_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset(input logic [2:0] fs);
    rst = 1'b1; fifo_status = fs; level_mode = '0; dma_active = '0;
    err_strobe = '0; clr_we = 1'b0; clr_mask = '0; irq_enable = '0; top_enable = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic write_clear(input logic [8:0] m);
    clr_we = 1'b1; clr_mask = m;
    step();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset;
    do_reset(3'b000);
    chk("R1 flags", flags_o, 9'd0);
    step();
    chk("R1 flags after release", flags_o, 9'd0);
    chk("R1 irq", {8'd0, irq_o}, 9'd0);
  endtask

  task automatic t_edge;
    do_reset(3'b000);
    fifo_status[1] = 1'b1;
    step();
    chk("R2 rise sets", flags_o, 9'b000000010);
    write_clear(9'b000000010);
    chk("R2 cleared while high", flags_o, 9'd0);
    step(3);
    chk("R2 no re-fire while high", flags_o, 9'd0);
    fifo_status[1] = 1'b0;
    step();
    fifo_status[1] = 1'b1;
    step();
    chk("R2 second rise", flags_o, 9'b000000010);
  endtask

  task automatic t_level;
    do_reset(3'b000);
    level_mode = 3'b100;
    fifo_status[2] = 1'b1;
    step();
    chk("R3 level sets", flags_o, 9'b000000100);
    write_clear(9'b000000100);
    chk("R3 clear while high holds", flags_o, 9'b000000100);
    fifo_status[2] = 1'b0;
    step();
    write_clear(9'b000000100);
    chk("R3 clear once low", flags_o, 9'd0);
  endtask

  task automatic t_dma;
    do_reset(3'b000);
    dma_active = 4'b1111;
    step(2);
    chk("R4 rise no effect", flags_o, 9'd0);
    dma_active[0] = 1'b0;
    step();
    chk("R4 tx A done", flags_o, 9'b000001000);
    dma_active[3:1] = 3'b000;
    step();
    chk("R4 all done", flags_o, 9'b001111000);
  endtask

  task automatic t_err;
    do_reset(3'b000);
    err_strobe = 2'b01;
    step();
    err_strobe = 2'b00;
    chk("R5 overrun", flags_o, 9'b010000000);
    err_strobe = 2'b10;
    step();
    err_strobe = 2'b00;
    step(2);
    chk("R5/R6 underrun sticky", flags_o, 9'b110000000);
    write_clear(9'b010000000);
    chk("R6 selective clear", flags_o, 9'b100000000);
  endtask

  task automatic t_race;
    do_reset(3'b000);
    err_strobe = 2'b10;
    step();
    err_strobe = 2'b10;
    clr_we = 1'b1; clr_mask = 9'b100000000;
    step();
    err_strobe = 2'b00; clr_we = 1'b0; clr_mask = '0;
    chk("R7 event beats clear", flags_o, 9'b100000000);
    write_clear(9'b100000000);
    chk("R7 plain clear afterwards", flags_o, 9'd0);
  endtask

  task automatic t_irq;
    do_reset(3'b000);
    err_strobe = 2'b10;
    step();
    err_strobe = 2'b00;
    top_enable = 1'b1; irq_enable = 9'd0;
    #1;
    chk("R8 masked flag", {8'd0, irq_o}, 9'd0);
    chk("R8 masked flag visible", flags_o, 9'b100000000);
    irq_enable = 9'b100000000; top_enable = 1'b0;
    #1;
    chk("R8 top disabled", {8'd0, irq_o}, 9'd0);
    top_enable = 1'b1;
    #1;
    chk("R8 request", {8'd0, irq_o}, 9'd1);
    irq_enable = 9'b011111111;
    #1;
    chk("R8 other bits enabled", {8'd0, irq_o}, 9'd0);
  endtask

  task automatic t_reset_edge;
    do_reset(3'b001);
    step();
    chk("R9 high at release", flags_o, 9'b000000001);
    write_clear(9'b000000001);
    step(2);
    chk("R9 counted once", flags_o, 9'd0);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_dma();
    t_err();
    t_race();
    t_irq();
    t_reset_edge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule